// File: doc/BRIEF.md
# Two-Port Memory with Address-Collision Arbitration

This block is a synchronous two-port word memory with a left and a right port that both reach every location in the same clock domain. Each port carries an active-low select, a read/write level (high reads, low writes), an active-low output enable, two active-low byte-lane selects and its own address, write-data and read-data buses. Reads are registered: the word appears on the read bus in the cycle after the request. Any lane that is not being read returns zero.

When both ports are selected on the same address, a three-state arbiter picks a winner. The default is a first-come rule: a port that already held its select and address in the previous cycle beats a newcomer. If both ports arrive in the same cycle, the left port wins. The loser sees its active-low busy flag go low in the same cycle, and its writes are blocked inside the block. States: `ARB_IDLE` (no holder). `ARB_LEFT_HOLD` (left owns the collision, right busy low). `ARB_RIGHT_HOLD` (mirror). Transitions:
- `ARB_IDLE` to a hold state happens on a match, with the winner picked as above.
- A hold state stays put while the match lasts.
- A hold state returns to `ARB_IDLE` after its first cycle without a match. During that cycle busy is still low.

A mode strap selects master or slave. In master mode the arbiter drives the busy outputs. In slave mode the busy outputs stay high, and each port's external busy input, when low, blocks that port's writes.

Top module: `dpr_collide_top`

## Requirements
- R1: In master mode both busy outputs are high in any cycle where there is no collision (both selects low and equal addresses) in that cycle or in the previous cycle.
- R2: On a collision starting from `ARB_IDLE`, a port whose select was low on the same address in the previous cycle wins over a port that was not. The loser's busy output goes low in that same cycle.
- R3: The two busy outputs are never low at the same time.
- R4: In master mode, a write from a port whose busy output is low leaves the memory unchanged, while the winner's write is stored.
- R5: Arbitration uses only select and address. A reading port that arrived first still wins against a newcomer that writes.
- R6: In slave mode both busy outputs are high. A low busy input blocks only that port's writes and leaves its reads and the other port unaffected.
- R7: Upper lane select gates bits 15:8 and lower lane select gates bits 7:0, for both writes and reads. An unread lane returns zero. With both selects high, a write changes nothing.
- R8: A port reads only when select is low, read/write is high and output enable is low. The data appears one cycle later; otherwise the read bus is zero.
- R9: When both ports start a collision in the same cycle, the left port wins and the right busy output goes low.
- R10: Once set, the loser's busy stays low for as long as the collision lasts. It stays low in the first cycle after the collision ends and is high in the cycle after that.
- R11: Two simultaneous reads of one address return the same stored word on both ports, with busy behaving as for any collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1: arbiter drives busy; 0: busy inputs inhibit writes |
| l_cs_n | input | 1 | Left select, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper lane select, active low |
| l_lb_n | input | 1 | Left lower lane select, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_in_n | input | 1 | Left external write inhibit (slave mode) |
| l_busy_out_n | output | 1 | Left busy flag, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper lane select, active low |
| r_lb_n | input | 1 | Right lower lane select, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_in_n | input | 1 | Right external write inhibit (slave mode) |
| r_busy_out_n | output | 1 | Right busy flag, active low |

## Verification
The bench builds the block with a 6-bit address and the default 16-bit word. The 64-word array keeps elaboration small, while every lane, arbitration and mode path stays the same as at full depth. With this width the directed collisions cover three orderings: first arrival on either side, same-cycle arrival, and holds of several cycles with release. The write blocking is confirmed by reading the stored words back after each collision.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        ARB_IDLE       = 2'd0,
        ARB_LEFT_HOLD  = 2'd1,
        ARB_RIGHT_HOLD = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [LANES-1:0] lanes;   // [1] upper, [0] lower
    } port_cmd_t;
endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
    import dpr_pkg::*;
(
    input  logic      cs_n,
    input  logic      rw,
    input  logic      oe_n,
    input  logic      ub_n,
    input  logic      lb_n,
    input  logic      inhibit,
    output port_cmd_t cmd
);
    always_comb begin
        cmd.lanes = {~ub_n, ~lb_n};
        cmd.rd    = ~cs_n & rw & ~oe_n;
        cmd.wr    = ~cs_n & ~rw & ~inhibit & (|cmd.lanes);
    end
endmodule

// File: rtl/dpr_collision_fsm.sv
module dpr_collision_fsm
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_lose,
    output logic              r_lose
);
    arb_state_e        state_q, state_d;
    logic              l_en_q, r_en_q;
    logic [ADDR_W-1:0] l_addr_q, r_addr_q;
    logic              match, l_old, r_old, right_first;

    always_comb begin
        match       = l_en & r_en & (l_addr == r_addr);
        l_old       = l_en_q & (l_addr_q == l_addr);
        r_old       = r_en_q & (r_addr_q == r_addr);
        right_first = r_old & ~l_old;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ARB_IDLE;
            l_en_q   <= 1'b0;
            r_en_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            state_q  <= state_d;
            l_en_q   <= l_en;
            r_en_q   <= r_en;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:
                if (match) state_d = right_first ? ARB_RIGHT_HOLD : ARB_LEFT_HOLD;
            ARB_LEFT_HOLD:
                if (!match) state_d = ARB_IDLE;
            ARB_RIGHT_HOLD:
                if (!match) state_d = ARB_IDLE;
            default: state_d = ARB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        l_lose = 1'b0;
        r_lose = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                l_lose = match & right_first;
                r_lose = match & ~right_first;
            end
            ARB_LEFT_HOLD:  r_lose = 1'b1;
            ARB_RIGHT_HOLD: l_lose = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dpr_storage.sv
module dpr_storage
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_cmd_t         l_cmd,
    input  port_cmd_t         r_cmd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] l_mask, r_mask;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_mask
            assign l_mask[g*LANE_W +: LANE_W] = {LANE_W{l_cmd.lanes[g]}};
            assign r_mask[g*LANE_W +: LANE_W] = {LANE_W{r_cmd.lanes[g]}};
        end
    endgenerate

    // right applied first so a left write to the same word takes precedence
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (r_cmd.wr && r_cmd.lanes[i])
                mem[r_addr][i*LANE_W +: LANE_W] <= r_wdata[i*LANE_W +: LANE_W];
            if (l_cmd.wr && l_cmd.lanes[i])
                mem[l_addr][i*LANE_W +: LANE_W] <= l_wdata[i*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            l_rdata <= l_cmd.rd ? (mem[l_addr] & l_mask) : '0;
            r_rdata <= r_cmd.rd ? (mem[r_addr] & r_mask) : '0;
        end
    end
endmodule

// File: rtl/dpr_collide_top.sv
module dpr_collide_top
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              l_cs_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_in_n,
    output logic              l_busy_out_n,
    input  logic              r_cs_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_in_n,
    output logic              r_busy_out_n
);
    logic      l_lose, r_lose, l_inh, r_inh;
    port_cmd_t l_cmd, r_cmd;

    dpr_collision_fsm #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .l_en(~l_cs_n), .r_en(~r_cs_n),
        .l_addr(l_addr), .r_addr(r_addr),
        .l_lose(l_lose), .r_lose(r_lose)
    );

    always_comb begin
        l_inh        = is_master ? l_lose : ~l_busy_in_n;
        r_inh        = is_master ? r_lose : ~r_busy_in_n;
        l_busy_out_n = ~(is_master & l_lose);
        r_busy_out_n = ~(is_master & r_lose);
    end

    dpr_port_ctrl u_lctl (
        .cs_n(l_cs_n), .rw(l_rw), .oe_n(l_oe_n), .ub_n(l_ub_n), .lb_n(l_lb_n),
        .inhibit(l_inh), .cmd(l_cmd)
    );

    dpr_port_ctrl u_rctl (
        .cs_n(r_cs_n), .rw(r_rw), .oe_n(r_oe_n), .ub_n(r_ub_n), .lb_n(r_lb_n),
        .inhibit(r_inh), .cmd(r_cmd)
    );

    dpr_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .l_cmd(l_cmd), .r_cmd(r_cmd),
        .l_addr(l_addr), .r_addr(r_addr),
        .l_wdata(l_wdata), .r_wdata(r_wdata),
        .l_rdata(l_rdata), .r_rdata(r_rdata)
    );
endmodule

// File: rtl/dpr_collide_chk.sv
module dpr_collide_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              is_master,
    input logic              l_cs_n,
    input logic              r_cs_n,
    input logic              l_rw,
    input logic              r_rw,
    input logic              l_oe_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic [DATA_W-1:0] r_rdata,
    input logic              l_busy_out_n,
    input logic              r_busy_out_n
);
    logic seen;
    logic hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assign hit = ~l_cs_n & ~r_cs_n & (l_addr == r_addr);

    a_r3_never_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_out_n && !r_busy_out_n));

    a_r1_quiet_without_match: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && is_master && !hit && !$past(hit)) |-> (l_busy_out_n && r_busy_out_n));

    a_r2_one_loser_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && hit) |-> ($countones({l_busy_out_n, r_busy_out_n}) == 1));

    a_r6_slave_outputs_high: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (l_busy_out_n && r_busy_out_n));

    a_r10_loser_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && is_master && $past(is_master) && $past(hit) && hit && $past(!r_busy_out_n))
            |-> !r_busy_out_n);

    a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (l_cs_n || !l_rw || l_oe_n) |=> (l_rdata == '0));

    a_r8_idle_read_zero_r: assert property (@(posedge clk) disable iff (!rst_n)
        (r_cs_n || !r_rw || r_oe_n) |=> (r_rdata == '0));
endmodule

bind dpr_collide_top dpr_collide_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .l_cs_n(l_cs_n), .r_cs_n(r_cs_n), .l_rw(l_rw), .r_rw(r_rw),
    .l_oe_n(l_oe_n), .r_oe_n(r_oe_n), .l_addr(l_addr), .r_addr(r_addr),
    .l_rdata(l_rdata), .r_rdata(r_rdata),
    .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n)
);

// File: tb/tb_dpr_collide_top.sv
`timescale 1ns/1ps
module tb_dpr_collide_top;
    localparam int AW = 6;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_master = 1'b1;
    logic l_cs_n = 1, l_rw = 1, l_oe_n = 1, l_ub_n = 1, l_lb_n = 1, l_busy_in_n = 1;
    logic r_cs_n = 1, r_rw = 1, r_oe_n = 1, r_ub_n = 1, r_lb_n = 1, r_busy_in_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_busy_out_n, r_busy_out_n;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    dpr_collide_top #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic l_drive(input logic cs_n, rw, oe_n, ub_n, lb_n,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_cs_n = cs_n; l_rw = rw; l_oe_n = oe_n; l_ub_n = ub_n; l_lb_n = lb_n;
        l_addr = a; l_wdata = d;
    endtask

    task automatic r_drive(input logic cs_n, rw, oe_n, ub_n, lb_n,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_cs_n = cs_n; r_rw = rw; r_oe_n = oe_n; r_ub_n = ub_n; r_lb_n = lb_n;
        r_addr = a; r_wdata = d;
    endtask

    task automatic idle_both();
        @(negedge clk);
        l_drive(1, 1, 1, 1, 1, '0, '0);
        r_drive(1, 1, 1, 1, 1, '0, '0);
        @(negedge clk);
    endtask

    task automatic l_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic ub_n, lb_n);
        @(negedge clk);
        l_drive(0, 0, 1, ub_n, lb_n, a, d);
        @(negedge clk);
        l_drive(1, 1, 1, 1, 1, '0, '0);
    endtask

    task automatic l_read(input logic [AW-1:0] a, input logic ub_n, lb_n, output logic [DW-1:0] q);
        @(negedge clk);
        l_drive(0, 1, 0, ub_n, lb_n, a, '0);
        @(posedge clk); #1;
        q = l_rdata;
        @(negedge clk);
        l_drive(1, 1, 1, 1, 1, '0, '0);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 reset busy_l", {15'd0, l_busy_out_n}, 16'd1);
        chk("R1 reset busy_r", {15'd0, r_busy_out_n}, 16'd1);
        chk("R8 reset rdata", l_rdata, 16'h0000);
    endtask

    task automatic t_lanes();
        logic [DW-1:0] q;
        l_write(6'd3, 16'hA1B2, 0, 0);
        l_read(6'd3, 0, 0, q);  chk("R7 full word", q, 16'hA1B2);
        l_write(6'd3, 16'h5566, 0, 1);
        l_read(6'd3, 0, 0, q);  chk("R7 upper only write", q, 16'h55B2);
        l_write(6'd3, 16'h7788, 1, 0);
        l_read(6'd3, 0, 0, q);  chk("R7 lower only write", q, 16'h5588);
        l_read(6'd3, 0, 1, q);  chk("R7 upper only read", q, 16'h5500);
        l_read(6'd3, 1, 0, q);  chk("R7 lower only read", q, 16'h0088);
        l_write(6'd3, 16'hFFFF, 1, 1);
        l_read(6'd3, 0, 0, q);  chk("R7 deselected write ignored", q, 16'h5588);
        l_read(6'd3, 1, 1, q);  chk("R7 deselected read zero", q, 16'h0000);
    endtask

    task automatic t_read_gate();
        @(negedge clk);
        l_drive(0, 1, 1, 0, 0, 6'd3, '0);
        @(posedge clk); #1;
        chk("R8 oe high gives zero", l_rdata, 16'h0000);
        @(negedge clk);
        l_drive(1, 1, 0, 0, 0, 6'd3, '0);
        @(posedge clk); #1;
        chk("R8 cs high gives zero", l_rdata, 16'h0000);
        @(negedge clk);
        l_drive(0, 0, 0, 0, 0, 6'd9, 16'h1234);
        @(posedge clk); #1;
        chk("R8 write gives zero", l_rdata, 16'h0000);
        idle_both();
    endtask

    task automatic t_no_match();
        @(negedge clk);
        l_drive(0, 0, 1, 0, 0, 6'd10, 16'h1010);
        r_drive(0, 0, 1, 0, 0, 6'd11, 16'h1111);
        #1;
        chk("R1 different addr busy_l", {15'd0, l_busy_out_n}, 16'd1);
        chk("R1 different addr busy_r", {15'd0, r_busy_out_n}, 16'd1);
        idle_both();
    endtask

    task automatic t_left_first();
        logic [DW-1:0] q;
        @(negedge clk);
        l_drive(0, 0, 1, 0, 0, 6'd20, 16'h2001);
        @(negedge clk);
        l_drive(0, 0, 1, 0, 0, 6'd20, 16'h2002);
        r_drive(0, 0, 1, 0, 0, 6'd20, 16'hDEAD);
        #1;
        chk("R2 newcomer right busy low", {15'd0, r_busy_out_n}, 16'd0);
        chk("R2 holder left busy high", {15'd0, l_busy_out_n}, 16'd1);
        chk("R3 not both low", {15'd0, l_busy_out_n | r_busy_out_n}, 16'd1);
        idle_both();
        idle_both();
        l_read(6'd20, 0, 0, q);
        chk("R4 loser write blocked", q, 16'h2002);
    endtask

    task automatic t_same_cycle();
        logic [DW-1:0] q;
        @(negedge clk);
        l_drive(0, 0, 1, 0, 0, 6'd21, 16'h1EF7);
        r_drive(0, 0, 1, 0, 0, 6'd21, 16'h0BAD);
        #1;
        chk("R9 left wins busy_l high", {15'd0, l_busy_out_n}, 16'd1);
        chk("R9 right loses busy_r low", {15'd0, r_busy_out_n}, 16'd0);
        idle_both();
        idle_both();
        l_read(6'd21, 0, 0, q);
        chk("R4 same-cycle left data kept", q, 16'h1EF7);
    endtask

    task automatic t_hold_release();
        @(negedge clk);
        l_drive(0, 1, 1, 0, 0, 6'd30, '0);
        r_drive(0, 1, 1, 0, 0, 6'd30, '0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R10 held during match", {15'd0, r_busy_out_n}, 16'd0);
        end
        r_drive(1, 1, 1, 1, 1, '0, '0);
        #1;
        chk("R10 still low one cycle after", {15'd0, r_busy_out_n}, 16'd0);
        @(negedge clk); #1;
        chk("R10 released", {15'd0, r_busy_out_n}, 16'd1);
        idle_both();
    endtask

    task automatic t_rw_indep();
        logic [DW-1:0] q;
        l_write(6'd40, 16'h4040, 0, 0);
        @(negedge clk);
        r_drive(0, 1, 0, 0, 0, 6'd40, '0);
        @(negedge clk);
        l_drive(0, 0, 1, 0, 0, 6'd40, 16'hBEEF);
        #1;
        chk("R5 reading holder wins, left busy low", {15'd0, l_busy_out_n}, 16'd0);
        chk("R5 right busy high", {15'd0, r_busy_out_n}, 16'd1);
        idle_both();
        idle_both();
        l_read(6'd40, 0, 0, q);
        chk("R5 writing newcomer blocked", q, 16'h4040);
    endtask

    task automatic t_dual_read();
        @(negedge clk);
        l_drive(0, 1, 0, 0, 0, 6'd40, '0);
        r_drive(0, 1, 0, 0, 0, 6'd40, '0);
        #1;
        chk("R11 busy_r low on shared read", {15'd0, r_busy_out_n}, 16'd0);
        @(posedge clk); #1;
        chk("R11 left read data", l_rdata, 16'h4040);
        chk("R11 right read data", r_rdata, 16'h4040);
        idle_both();
        idle_both();
    endtask

    task automatic t_slave();
        logic [DW-1:0] q;
        @(negedge clk);
        is_master = 1'b0;
        l_busy_in_n = 1'b0;
        l_drive(0, 0, 1, 0, 0, 6'd50, 16'h5050);
        r_drive(0, 0, 1, 0, 0, 6'd51, 16'h5151);
        #1;
        chk("R6 slave busy_l out high", {15'd0, l_busy_out_n}, 16'd1);
        chk("R6 slave busy_r out high", {15'd0, r_busy_out_n}, 16'd1);
        idle_both();
        l_read(6'd51, 0, 0, q);
        chk("R6 right write unaffected", q, 16'h5151);
        chk("R6 left read works while inhibited", {15'd0, q != 16'h0000}, 16'd1);
        l_busy_in_n = 1'b1;
        l_write(6'd50, 16'h0A0A, 0, 0);
        l_busy_in_n = 1'b0;
        l_write(6'd50, 16'hFFFF, 0, 0);
        l_read(6'd50, 0, 0, q);
        chk("R6 left write inhibited by busy input", q, 16'h0A0A);
        l_busy_in_n = 1'b1;
        is_master = 1'b1;
        idle_both();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_lanes();
        t_read_gate();
        t_no_match();
        t_left_first();
        t_same_cycle();
        t_hold_release();
        t_rw_indep();
        t_dual_read();
        t_slave();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule